// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block maps a physical address onto one of four programmable memory banks. Software writes two 32-bit configuration registers, and each holds two 16-bit bank descriptors. A descriptor carries three fields: an enable flag, a base field and a size field. When a lookup request arrives, the decoder turns each enabled descriptor into an address window and tests the address against all four windows at once. The result arrives one clock later as a one-hot bank select, a miss flag and the distance of the address from the start of the selected bank.

Base and size are scaled by shift amounts. A revision input chooses one of two pairs of shifts, so the same descriptor covers a larger or a smaller window depending on the revision.

Top module: `membank_decoder`

## Requirements
- R1: After reset both configuration registers are zero, every bank is disabled, and any request then misses.
- R2: A write with `cfg_sel`=0 loads register 0, which holds bank 0 in bits 31:16 and bank 1 in bits 15:0. A write with `cfg_sel`=1 loads register 1, which holds bank 2 in bits 31:16 and bank 3 in bits 15:0. A request sampled at a later edge than the write sees the new value.
- R3: Descriptor layout: bit 13 enables the bank, bits 12:8 are the size field, bits 7:0 are the base field. Bits 15:14 have no effect on decoding.
- R4: A bank whose enable bit is 0 never hits, whatever its base and size.
- R5: When `rev` >= 5, base = base field << 24 and size = (size field + 0x100) << 16.
- R6: When `rev` < 5, base = base field << 22 and size = (size field + 0x100) << 14.
- R7: A bank hits when base <= address < base + size. The lower bound is included and the upper bound is excluded.
- R8: When several enabled windows contain the address, only the lowest-numbered bank is reported.
- R9: On a hit, `rsp_offset` = address - base of the reported bank and `rsp_miss` = 0. On a miss, `rsp_hit` = 0, `rsp_miss` = 1 and `rsp_offset` = 0.
- R10: Results appear on the clock edge after the request is sampled, with `rsp_valid` high for one cycle per request. While `rsp_valid` is low, `rsp_hit`, `rsp_miss` and `rsp_offset` are zero.
- R11: The window end is computed one bit wider than the address, so a bank reaching past the top of the address space still covers the highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Register select: 0 for banks 0/1, 1 for banks 2/3 |
| cfg_wdata | input | 32 | Configuration write data |
| rev | input | REV_W | Revision value that selects the scaling |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Address to decode |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_hit | output | 4 | One-hot select of the hitting bank |
| rsp_miss | output | 1 | No enabled bank contains the address |
| rsp_offset | output | ADDR_W | Address minus the base of the hitting bank |

## Verification
The bench uses the default parameters: a 32-bit address, a revision split at 5, and shifts of 24/22 for the base and 16/14 for the size.

With a 32-bit address, a bank with base field 0xFF and the largest size field extends past 2^32, which exercises the wide end compare. Revision values 4 and 5 lie on either side of the split, so one set of descriptors is decoded under both scalings. The stimulus includes overlapping windows, disabled banks with non-zero fields, and set bits in the unused descriptor bits.

// File: rtl/membank_decoder.sv
module membank_decoder #(
  parameter int ADDR_W     = 32,
  parameter int REV_W      = 4,
  parameter int REV_SPLIT  = 5,
  parameter int BASE_SH_HI = 24,
  parameter int BASE_SH_LO = 22,
  parameter int SIZE_SH_HI = 16,
  parameter int SIZE_SH_LO = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [REV_W-1:0]  rev,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [3:0]        rsp_hit,
  output logic              rsp_miss,
  output logic [ADDR_W-1:0] rsp_offset
);
  localparam int NB     = 4;
  localparam int WIDE   = ADDR_W + 1;
  localparam int EN_BIT = 13;
  localparam int SZ_MSB = 12;
  localparam int SZ_LSB = 8;
  localparam int BA_MSB = 7;
  localparam int SZ_W   = SZ_MSB - SZ_LSB + 1;

  logic [31:0] cfg_r0, cfg_r1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r0 <= '0;
      cfg_r1 <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) cfg_r1 <= cfg_wdata;
      else         cfg_r0 <= cfg_wdata;
    end
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_r0[31:30], cfg_r0[15:14], cfg_r1[31:30], cfg_r1[15:14]};

  logic       wide_scale;
  logic [5:0] base_sh, size_sh;
  assign wide_scale = rev >= REV_W'(REV_SPLIT);
  assign base_sh    = wide_scale ? 6'(BASE_SH_HI) : 6'(BASE_SH_LO);
  assign size_sh    = wide_scale ? 6'(SIZE_SH_HI) : 6'(SIZE_SH_LO);

  logic [WIDE-1:0] addr_w;
  assign addr_w = {1'b0, req_addr};

  logic [NB-1:0]   bank_en, in_win;
  logic [WIDE-1:0] base_w [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [31:0]     src;
    logic [15:0]     desc;
    logic [WIDE-1:0] size_w, end_w;
    assign src       = (g / 2 == 0) ? cfg_r0 : cfg_r1;
    assign desc      = (g % 2 == 0) ? src[31:16] : src[15:0];
    assign bank_en[g] = desc[EN_BIT];
    assign base_w[g] = WIDE'(desc[BA_MSB:0]) << base_sh;
    assign size_w    = (WIDE'(desc[SZ_MSB:SZ_LSB]) + WIDE'(1 << (BA_MSB + 1))) << size_sh;
    assign end_w     = base_w[g] + size_w;
    assign in_win[g] = bank_en[g] && (addr_w >= base_w[g]) && (addr_w < end_w);
  end

  logic [NB-1:0]     win;
  logic [ADDR_W-1:0] off_c;
  assign win = in_win & (~in_win + NB'(1));

  always_comb begin
    off_c = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (in_win[i]) off_c = ADDR_W'(addr_w - base_w[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= '0;
      rsp_miss   <= 1'b0;
      rsp_offset <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid ? win : '0;
      rsp_miss   <= req_valid && (in_win == '0);
      rsp_offset <= req_valid ? off_c : '0;
    end
  end

  assert_onehot_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_hit));
  assert_miss_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_miss != (|rsp_hit)));
  assert_miss_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_offset == '0));
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_hit == '0 && !rsp_miss && rsp_offset == '0));

  for (genvar g = 0; g < NB; g++) begin : g_chk
    assert_disabled_nohit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit[g] |-> $past(bank_en[g]));
  end
endmodule

// File: tb/membank_decoder_tb.sv
module membank_decoder_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [3:0]    rev = 4'd5;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [3:0]    rsp_hit;
  logic          rsp_miss;
  logic [AW-1:0] rsp_offset;

  membank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rev(rev), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_offset(rsp_offset)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [3:0]  hit;
    logic        miss;
    logic [31:0] off;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_fail = 0;
  logic [31:0] sh_r0 = '0, sh_r1 = '0;
  logic        mon_on = 1'b0;

  function automatic exp_t model(logic [31:0] a, logic [3:0] rv, string tag);
    exp_t e;
    e.hit = '0; e.off = '0; e.tag = tag;
    for (int i = 3; i >= 0; i--) begin
      logic [31:0] w;
      logic [15:0] d;
      logic [32:0] b, s;
      w = (i < 2) ? sh_r0 : sh_r1;
      d = (i % 2 == 0) ? w[31:16] : w[15:0];
      b = 33'(d[7:0]) << ((rv >= 4'd5) ? 24 : 22);
      s = (33'(d[12:8]) + 33'h100) << ((rv >= 4'd5) ? 16 : 14);
      if (d[13] && {1'b0, a} >= b && {1'b0, a} < b + s) begin
        e.hit = 4'b1 << i;
        e.off = 32'({1'b0, a} - b);
      end
    end
    e.miss = (e.hit == '0);
    return e;
  endfunction

  task automatic issue(input logic [31:0] a, input logic [3:0] rv, input string tag);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b1; req_addr = a; rev = rv;
    sb.push_back(model(a, rv, tag));
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    if (sel) sh_r1 = d; else sh_r0 = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (rsp_valid) begin
        n_checks++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R10 unexpected result: actual valid=1 expected no result");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rsp_hit !== e.hit || rsp_miss !== e.miss || rsp_offset !== e.off) begin
            n_fail++;
            $display("FAIL %s: actual hit=%b miss=%b off=%h expected hit=%b miss=%b off=%h",
                     e.tag, rsp_hit, rsp_miss, rsp_offset, e.hit, e.miss, e.off);
          end
        end
      end else if (rsp_hit !== '0 || rsp_miss !== 1'b0 || rsp_offset !== '0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R10 idle outputs: actual hit=%b miss=%b off=%h expected all zero",
                 rsp_hit, rsp_miss, rsp_offset);
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual run still busy expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== '0 || rsp_miss !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: actual v=%b hit=%b miss=%b expected 0/0000/0",
               rsp_valid, rsp_hit, rsp_miss);
    end
    mon_on = 1'b1;

    issue(32'h0000_0000, 4'd5, "R1 zero address after reset");
    issue(32'h0100_0000, 4'd5, "R1 any address after reset");

    // bank0: enable, size 0, base 0x01; bank1: enable, size 0x1F, base 0x02
    wr(1'b0, 32'h2001_3F02);
    issue(32'h0100_0000, 4'd5, "R7 R5 bank0 lower bound");
    issue(32'h01FF_FFFF, 4'd5, "R7 R5 bank0 last byte");
    issue(32'h0200_0000, 4'd5, "R2 R5 bank1 lower bound");
    issue(32'h031E_FFFF, 4'd5, "R5 bank1 size field last byte");
    issue(32'h031F_0000, 4'd5, "R7 bank1 upper bound excluded");
    issue(32'h00FF_FFFF, 4'd5, "R9 below all banks miss");

    issue(32'h0040_0000, 4'd4, "R6 bank0 lower bound");
    issue(32'h007F_FFFF, 4'd4, "R6 bank0 last byte");
    issue(32'h00C7_BFFF, 4'd4, "R6 bank1 last byte");
    issue(32'h00C7_C000, 4'd4, "R6 R7 bank1 end excluded");
    issue(32'h003F_FFFF, 4'd4, "R6 below bank0 miss");
    issue(32'h0100_0000, 4'd4, "R6 beyond scaled banks miss");

    // bank2 disabled but base 0x01 plus bit15; bank3 enabled base 0x01 plus bit14
    wr(1'b1, 32'h8001_6001);
    issue(32'h0100_0000, 4'd5, "R8 overlap lowest bank wins");
    issue(32'h0180_0000, 4'd5, "R8 overlap interior");
    wr(1'b0, 32'h0000_0000);
    issue(32'h0100_0000, 4'd5, "R4 R3 disabled bank2 skipped, bank3 hits");
    issue(32'h0123_4567, 4'd5, "R3 unused bits ignored offset");
    issue(32'h0040_0000, 4'd4, "R3 R6 bank3 old scaling");

    // bank2: enable, size 0x1F, base 0xFF reaching past 2^32; bank3 off
    wr(1'b1, 32'h3FFF_0000);
    issue(32'hFFFF_FFFF, 4'd5, "R11 top address covered");
    issue(32'hFF00_0000, 4'd5, "R11 R2 bank2 lower bound");
    issue(32'h0000_0010, 4'd5, "R11 no wrap into low addresses");
    issue(32'h3FC0_0000, 4'd4, "R6 R2 bank2 old scaling");
    idle(4);

    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R10 missing results: actual pending=%0d expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule